// File: doc/BRIEF.md
# Multi-Mode Programmable Timer

A single-channel timer/counter controlled through a small register port. Software writes a control word that picks one of four operating modes, the counting direction, whether the counter restarts by itself, the divisor of the internal tick and whether a timeout raises an interrupt. A run bit starts and stops counting. Depending on the mode, the counter advances on a prescaled copy of the system clock or on rising edges of an external event input.

Counting up runs from zero towards a compare value, and counting down runs from a reload value towards zero. Reaching the end of the count is a timeout. A timeout sets a sticky status flag, which in turn drives an interrupt request when enabled. One-shot mode stops itself after its first timeout. PWM mode counts up over a period set by the compare value and drives a pulse output from a separate duty register.

Top module: `prog_timer`

## Requirements
- R1: After synchronous reset every register reads 0, the count reads 0, and `pwm_out` and `irq` are 0.
- R2: Register addresses are 0 control, 1 reload, 2 compare, 3 duty, 4 count (read only), 5 status. Any other address reads 0. Control bits are [1:0] mode, [2] run, [4:3] tick select, [5] down, [6] auto-restart and [7] interrupt enable, and they read back as written. The mode codes are 00 periodic, 01 event, 10 one-shot and 11 PWM.
- R3: A control write that changes run from 0 to 1 loads the count in that cycle. The count becomes the reload value if the new control word counts down, and 0 otherwise. While run is 0 the count holds its value.
- R4: When counting up, each tick adds one. The tick that would make the count equal to compare is a timeout. On that tick the count becomes 0 with auto-restart, and without auto-restart it becomes compare and stays there.
- R5: When counting down, each tick subtracts one. The tick that takes the count from 1 to 0 is a timeout. On that tick the count becomes the reload value with auto-restart, and without auto-restart it becomes 0 and stays there.
- R6: In periodic, one-shot and PWM modes a tick occurs every 2^(select*PRE_STEP) clocks after the start, where select is the 2-bit tick-select field.
- R7: In event mode the internal clock gives no ticks. The event input passes through a SYNC_STAGES flip-flop synchroniser, and each rising edge gives exactly one tick.
- R8: One-shot mode ignores auto-restart. Its first timeout clears the run bit, so the count stays at its end value.
- R9: PWM mode always counts up and always restarts, so its period is compare ticks. `pwm_out` is 1 while running with count below duty, and 0 otherwise.
- R10: Each timeout sets status bit 0 in the same cycle that the count updates. Writing 1 to that bit clears it, but a timeout in the same cycle as the clear leaves it set.
- R11: `irq` equals status bit 0 ANDed with the interrupt-enable control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Read data for reg_addr (combinational) |
| event_in | input | 1 | External event pulses, asynchronous |
| pwm_out | output | 1 | Pulse-width output |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with W=16, PRE_STEP=2 and SYNC_STAGES=2. With these values the tick divisors 1, 4 and 16 can be reached within a few dozen cycles, so the prescaled tick rate is checked exactly. The 16-bit width lets random periods from 2 to 31 run through several restarts in each direction with and without auto-restart. Directed cases line up a status clear with a timeout in the same cycle, follow an event through the synchroniser latency, and show that a one-shot run halts for good.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;

    typedef enum logic [1:0] {
        MODE_PERIODIC = 2'b00,
        MODE_EVENT    = 2'b01,
        MODE_ONESHOT  = 2'b10,
        MODE_PWM      = 2'b11
    } tmode_e;

    // first member is the most significant bit
    typedef struct packed {
        logic       irq_en;
        logic       auto_rl;
        logic       dir_down;
        logic [1:0] clk_sel;
        logic       run;
        tmode_e     mode;
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);
    localparam int ADDR_W    = 3;
    localparam int SEL_W     = 2;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP    = 3'd2;
    localparam logic [ADDR_W-1:0] A_DUTY   = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

    // PWM always counts up
    function automatic logic counts_down(tmode_e m, logic down);
        return down && (m != MODE_PWM);
    endfunction

    // PWM always restarts, one-shot never does
    function automatic logic restarts(tmode_e m, logic rl);
        case (m)
            MODE_PWM:     return 1'b1;
            MODE_ONESHOT: return 1'b0;
            default:      return rl;
        endcase
    endfunction

endpackage

// File: rtl/ptmr_regs.sv
`timescale 1ns/1ps
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      count,
    input  logic              timeout,
    input  logic              oneshot_done,
    output ctrl_t             ctrl,
    output logic [W-1:0]      reload_val,
    output logic [W-1:0]      compare_val,
    output logic [W-1:0]      duty_val,
    output logic              load,
    output logic [W-1:0]      load_val,
    output logic [W-1:0]      rdata,
    output logic              irq
);

    ctrl_t ctrl_q;
    ctrl_t ctrl_new;
    logic  sts_q;
    logic  wr_ctrl;
    logic  wr_stat_clr;

    assign ctrl_new    = ctrl_t'(wdata[CTRL_BITS-1:0]);
    assign wr_ctrl     = wr && (addr == A_CTRL);
    assign wr_stat_clr = wr && (addr == A_STAT) && wdata[0];

    // start: run goes 0 -> 1 through a control write
    assign load     = wr_ctrl && ctrl_new.run && !ctrl_q.run;
    assign load_val = counts_down(ctrl_new.mode, ctrl_new.dir_down) ? reload_val : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            reload_val  <= '0;
            compare_val <= '0;
            duty_val    <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_new;
            else if (oneshot_done)
                ctrl_q.run <= 1'b0;
            if (wr && addr == A_RELOAD) reload_val  <= wdata;
            if (wr && addr == A_CMP)    compare_val <= wdata;
            if (wr && addr == A_DUTY)   duty_val    <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            sts_q <= 1'b0;
        else if (timeout)
            sts_q <= 1'b1;
        else if (wr_stat_clr)
            sts_q <= 1'b0;
    end

    always_comb begin
        case (addr)
            A_CTRL:   rdata = W'(ctrl_q);
            A_RELOAD: rdata = reload_val;
            A_CMP:    rdata = compare_val;
            A_DUTY:   rdata = duty_val;
            A_COUNT:  rdata = count;
            A_STAT:   rdata = W'(sts_q);
            default:  rdata = '0;
        endcase
    end

    assign ctrl = ctrl_q;
    assign irq  = sts_q && ctrl_q.irq_en;

    // R10: a timeout always leaves the flag set
    assert_status_set_R10: assert property (@(posedge clk) disable iff (rst)
        timeout |=> sts_q);

    // R10: write-one clear without a competing timeout empties the flag
    assert_status_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_stat_clr && !timeout) |=> !sts_q);

    // R8: the one-shot end drops the run bit unless software rewrites control
    assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (oneshot_done && !wr_ctrl) |=> !ctrl_q.run);

endmodule

// File: rtl/ptmr_tick.sv
`timescale 1ns/1ps
module ptmr_tick
    import ptmr_pkg::*;
#(
    parameter int PRE_STEP    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  tmode_e           mode,
    input  logic             run,
    input  logic             load,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             event_in,
    output logic             tick
);

    localparam int PRE_W = PRE_STEP * ((1 << SEL_W) - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ev_last;
    logic                   ev_edge;
    logic [PRE_W-1:0]       presc;
    logic [PRE_W-1:0]       presc_lim;
    logic                   presc_hit;

    // synchroniser chain, depth picked by parameter
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= event_in;
            end
        end else begin : g_syncn
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], event_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ev_last <= 1'b0;
        else     ev_last <= sync_q[SYNC_STAGES-1];
    end

    assign ev_edge = sync_q[SYNC_STAGES-1] && !ev_last;

    assign presc_lim = PRE_W'((32'd1 << (32'(clk_sel) * PRE_STEP)) - 32'd1);
    assign presc_hit = (presc >= presc_lim);

    always_ff @(posedge clk) begin
        if (rst || load || !run)
            presc <= '0;
        else if (presc_hit)
            presc <= '0;
        else
            presc <= presc + 1'b1;
    end

    assign tick = run && ((mode == MODE_EVENT) ? ev_edge : presc_hit);

    // R7: an edge detector never reports two rising edges back to back
    assert_single_edge_R7: assert property (@(posedge clk) disable iff (rst)
        ev_edge |=> !ev_edge);

endmodule

// File: rtl/ptmr_core.sv
`timescale 1ns/1ps
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  tmode_e       mode,
    input  logic         run,
    input  logic         dir_down,
    input  logic         auto_rl,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    input  logic [W-1:0] compare_val,
    input  logic [W-1:0] duty_val,
    output logic [W-1:0] count,
    output logic         timeout,
    output logic         oneshot_done,
    output logic         pwm_out
);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_nx;
    logic [W-1:0] cnt_inc;
    logic         down_eff;
    logic         rl_eff;
    logic         step;
    logic         end_hit;

    assign down_eff = counts_down(mode, dir_down);
    assign rl_eff   = restarts(mode, auto_rl);
    assign step     = run && tick;
    assign cnt_inc  = cnt_q + 1'b1;

    always_comb begin
        cnt_nx  = cnt_q;
        end_hit = 1'b0;
        if (step) begin
            if (down_eff) begin
                if (cnt_q == '0) begin
                    if (rl_eff) begin
                        end_hit = 1'b1;
                        cnt_nx  = reload_val;
                    end
                end else if (cnt_q == W'(1)) begin
                    end_hit = 1'b1;
                    cnt_nx  = rl_eff ? reload_val : '0;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end else begin
                if (!rl_eff && cnt_q == compare_val) begin
                    cnt_nx = cnt_q;
                end else if (cnt_inc == compare_val) begin
                    end_hit = 1'b1;
                    cnt_nx  = rl_eff ? '0 : compare_val;
                end else begin
                    cnt_nx = cnt_inc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else           cnt_q <= cnt_nx;
    end

    assign count        = cnt_q;
    assign timeout      = end_hit && !load;
    assign oneshot_done = timeout && (mode == MODE_ONESHOT);
    assign pwm_out      = run && (mode == MODE_PWM) && (cnt_q < duty_val);

    // R3: a start places the selected start value in the counter
    assert_start_value_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

    // R4: timeouts only come from a tick while running
    assert_timeout_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (run && tick));

    // R5: an ordinary down tick subtracts exactly one
    assert_down_step_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !load && down_eff && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R4: an ordinary restarting up tick adds exactly one
    assert_up_step_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !down_eff && rl_eff && (cnt_q + 1'b1 != compare_val))
        |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R3: no run, no change
    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/prog_timer.sv
`timescale 1ns/1ps
module prog_timer
    import ptmr_pkg::*;
#(
    parameter int W           = 16,
    parameter int PRE_STEP    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    input  logic              event_in,
    output logic              pwm_out,
    output logic              irq
);

    ctrl_t        ctrl;
    logic [W-1:0] reload_val;
    logic [W-1:0] compare_val;
    logic [W-1:0] duty_val;
    logic [W-1:0] count;
    logic [W-1:0] load_val;
    logic         load;
    logic         tick;
    logic         timeout;
    logic         oneshot_done;

    ptmr_regs #(.W(W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr           (reg_wr),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .count        (count),
        .timeout      (timeout),
        .oneshot_done (oneshot_done),
        .ctrl         (ctrl),
        .reload_val   (reload_val),
        .compare_val  (compare_val),
        .duty_val     (duty_val),
        .load         (load),
        .load_val     (load_val),
        .rdata        (reg_rdata),
        .irq          (irq)
    );

    ptmr_tick #(.PRE_STEP(PRE_STEP), .SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .mode     (ctrl.mode),
        .run      (ctrl.run),
        .load     (load),
        .clk_sel  (ctrl.clk_sel),
        .event_in (event_in),
        .tick     (tick)
    );

    ptmr_core #(.W(W)) u_core (
        .clk          (clk),
        .rst          (rst),
        .mode         (ctrl.mode),
        .run          (ctrl.run),
        .dir_down     (ctrl.dir_down),
        .auto_rl      (ctrl.auto_rl),
        .tick         (tick),
        .load         (load),
        .load_val     (load_val),
        .reload_val   (reload_val),
        .compare_val  (compare_val),
        .duty_val     (duty_val),
        .count        (count),
        .timeout      (timeout),
        .oneshot_done (oneshot_done),
        .pwm_out      (pwm_out)
    );

endmodule

// File: tb/sim_prog_timer.sv
`timescale 1ns/1ps
module sim_prog_timer;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr = 1'b0;
    logic [2:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         event_in = 1'b0;
    logic         pwm_out;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    prog_timer #(.W(W), .PRE_STEP(2), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(event_in),
        .pwm_out(pwm_out), .irq(irq)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [W-1:0] cw(input int mode, input bit run, input int sel,
                                        input bit down, input bit rl, input bit ien);
        return W'({ien, rl, down, sel[1:0], run, mode[1:0]});
    endfunction

    function automatic int exp_up(input int n, input int c, input bit rl);
        if (rl) return n % c;
        return (n < c) ? n : c;
    endfunction

    function automatic int exp_dn(input int n, input int r, input bit rl);
        if (rl) return r - (n % r);
        return (n < r) ? r - n : 0;
    endfunction

    task automatic halt_and_clear();
        wr(3'd0, cw(0, 0, 0, 0, 0, 0));
        wr(3'd5, 16'd1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 0);
        rd(3'd4, v); chk("R1 count", v, 0);
        rd(3'd5, v); chk("R1 status", v, 0);
        chk("R1 pwm", pwm_out, 0);
        chk("R1 irq", irq, 0);

        // R2 control readback and unmapped address
        wr(3'd0, cw(3, 0, 2, 1, 1, 1));
        rd(3'd0, v); chk("R2 ctrl readback", v, 16'h00F3);
        rd(3'd6, v); chk("R2 unmapped", v, 0);
        wr(3'd2, 16'd1234);
        rd(3'd2, v); chk("R2 compare readback", v, 1234);
        halt_and_clear();

        // R4 up with auto-restart
        wr(3'd2, 16'd5);
        wr(3'd0, cw(0, 1, 0, 0, 1, 0));
        idle(3); rd(3'd4, v); chk("R4 up mid", v, 3);
        idle(2); rd(3'd4, v); chk("R4 up restart", v, 0);
        rd(3'd5, v); chk("R10 set by up timeout", v, 1);
        halt_and_clear();
        // R4 up without auto-restart
        wr(3'd0, cw(0, 1, 0, 0, 0, 0));
        idle(9); rd(3'd4, v); chk("R4 up hold at compare", v, 5);
        halt_and_clear();

        // R5 / R3 down with auto-restart
        wr(3'd1, 16'd4);
        wr(3'd0, cw(0, 1, 0, 1, 1, 0));
        rd(3'd4, v); chk("R3 start loads reload", v, 4);
        idle(3); rd(3'd4, v); chk("R5 down mid", v, 1);
        idle(1); rd(3'd4, v); chk("R5 down restart", v, 4);
        rd(3'd5, v); chk("R10 set by down timeout", v, 1);
        halt_and_clear();
        wr(3'd1, 16'd3);
        wr(3'd0, cw(0, 1, 0, 1, 0, 0));
        idle(6); rd(3'd4, v); chk("R5 down hold at zero", v, 0);
        halt_and_clear();

        // R3 freeze when stopped (stop edge still ticks once)
        wr(3'd2, 16'd1000);
        wr(3'd0, cw(0, 1, 0, 0, 1, 0));
        idle(10);
        wr(3'd0, cw(0, 0, 0, 0, 1, 0));
        idle(5); rd(3'd4, v); chk("R3 frozen count", v, 11);

        // R6 prescaler
        wr(3'd0, cw(0, 1, 1, 0, 1, 0));
        idle(22); rd(3'd4, v); chk("R6 divide by 4", v, 5);
        halt_and_clear();
        wr(3'd0, cw(0, 1, 2, 0, 1, 0));
        idle(50); rd(3'd4, v); chk("R6 divide by 16", v, 3);
        halt_and_clear();

        // R7 event counter
        wr(3'd0, cw(1, 1, 0, 0, 1, 0));
        idle(10); rd(3'd4, v); chk("R7 no internal ticks", v, 0);
        event_in = 1'b1; idle(2);
        rd(3'd4, v); chk("R7 synchroniser latency", v, 0);
        idle(1); rd(3'd4, v); chk("R7 first edge", v, 1);
        event_in = 1'b0; idle(2);
        repeat (4) begin
            event_in = 1'b1; idle(2);
            event_in = 1'b0; idle(2);
        end
        idle(4); rd(3'd4, v); chk("R7 five edges", v, 5);
        halt_and_clear();

        // R8 one-shot (auto-restart bit set but ignored)
        wr(3'd1, 16'd5);
        wr(3'd0, cw(2, 1, 0, 1, 1, 0));
        idle(3); rd(3'd4, v); chk("R8 one-shot mid", v, 2);
        idle(5); rd(3'd4, v); chk("R8 one-shot end", v, 0);
        rd(3'd0, v); chk("R8 run cleared", v[2], 0);
        rd(3'd5, v); chk("R8 status", v, 1);
        idle(6); rd(3'd4, v); chk("R8 stays halted", v, 0);
        halt_and_clear();

        // R9 PWM
        wr(3'd2, 16'd10);
        wr(3'd3, 16'd4);
        wr(3'd0, cw(3, 1, 0, 1, 0, 0));
        for (int k = 0; k < 20; k++) begin
            rd(3'd4, v); chk("R9 pwm count", v, k % 10);
            chk("R9 pwm level", pwm_out, ((k % 10) < 4) ? 1 : 0);
            idle(1);
        end
        wr(3'd0, cw(3, 0, 0, 0, 0, 0));
        chk("R9 pwm low when stopped", pwm_out, 0);
        halt_and_clear();

        // R10 timeout wins over clear in the same cycle, R11 irq gating
        wr(3'd2, 16'd6);
        wr(3'd0, cw(0, 1, 0, 0, 1, 0));
        idle(5);
        wr(3'd5, 16'd1);
        rd(3'd5, v); chk("R10 set wins over clear", v, 1);
        wr(3'd5, 16'd1);
        rd(3'd5, v); chk("R10 write-one clear", v, 0);
        idle(5);
        rd(3'd5, v); chk("R10 next timeout", v, 1);
        chk("R11 irq disabled", irq, 0);
        wr(3'd0, cw(0, 1, 0, 0, 1, 1));
        chk("R11 irq enabled", irq, 1);
        wr(3'd5, 16'd1);
        chk("R11 irq after clear", irq, 0);
        halt_and_clear();

        // R4 / R5 random periods and lengths
        for (int it = 0; it < 24; it++) begin
            bit dn = 1'($urandom % 2);
            bit rl = 1'($urandom % 2);
            int p  = 2 + int'($urandom % 30);
            int n  = int'($urandom % 90);
            int e;
            halt_and_clear();
            wr(3'd1, W'(p));
            wr(3'd2, W'(p));
            wr(3'd0, cw(0, 1, 0, dn, rl, 0));
            idle(n);
            e = dn ? exp_dn(n, p, rl) : exp_up(n, p, rl);
            rd(3'd4, v); chk(dn ? "R5 random count" : "R4 random count", v, e);
            rd(3'd5, v); chk("R10 random status", v, (n >= p) ? 1 : 0);
        end

        summary();
    end

endmodule